// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This unit adds or subtracts two 64-bit words that each hold a short vector of packed narrow integers. A two-bit packing input splits the word into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Every lane computes at the same time on one shared carry chain. That chain is cut at the lane edges chosen by the packing, so no carry or borrow passes from one lane into the next. A two-bit operation input chooses add or subtract, and chooses whether an out-of-range lane result wraps modulo the lane width or is clamped to the nearest representable limit. A separate input selects whether saturation treats lanes as signed or unsigned.

A word is accepted whenever the input strobe is high. The packed result is registered and comes out one clock later together with an output strobe. The interface has no back-pressure: there is no ready signal, the unit accepts a new word on every cycle, and a downstream consumer must take each result in the cycle it is flagged. Overflow never raises a signal of its own. It is fully absorbed by wrapping or by clamping.

Top module: `simd_sat_adder`

## Requirements
- R1: `out_vld` equals the value `in_vld` had at the previous rising clock edge, and it is 0 while `rst_n` is low and in the first cycle after reset.
- R2: When `in_vld` is low, `out_res` keeps its previous value at the next edge.
- R3: `in_mode` 2'b00 gives eight 8-bit lanes, 2'b01 gives four 16-bit lanes and 2'b10 gives two 32-bit lanes. Lane 0 sits in the least significant bits, and the result lanes are packed in the same order. 2'b11 behaves exactly like 2'b10.
- R4: `in_op` bit 0 selects subtract (1) or add (0), and bit 1 selects saturate (1) or wrap (0). With `in_op` = 2'b00, each result lane is (a + b) mod 2^w.
- R5: With `in_op` = 2'b01, each result lane is (a - b) mod 2^w.
- R6: No carry or borrow crosses a lane boundary in any mode.
- R7: Wrapping results do not depend on `in_signed`.
- R8: With saturation and `in_signed` = 1, a lane result above 2^(w-1)-1 becomes 2^(w-1)-1, and a result below -2^(w-1) becomes -2^(w-1).
- R9: A saturating unsigned add whose lane sum exceeds 2^w-1 returns 2^w-1 in that lane.
- R10: A saturating unsigned subtract whose lane difference is below 0 returns 0 in that lane.
- R11: In saturating modes, a lane whose exact result fits in the lane returns that exact result, whatever happens in the other lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input word strobe |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand (subtrahend) |
| in_mode | input | 2 | Lane packing select |
| in_op | input | 2 | Bit 0 subtract, bit 1 saturate |
| in_signed | input | 1 | Saturate lanes as signed integers |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| out_res | output | 64 | Packed lane results |

## Verification
The assertions check every cycle that the output strobe follows the input strobe with one cycle of delay and that the result holds while no input is flagged. They also check that the lowest byte of a wrapping result equals the byte-wide sum or difference in every packing. For 8-bit unsigned saturation, they check that the lowest lane never moves below its operand on an add or above it on a subtract. Exact per-lane clamp values, the cut carry chain at 16-bit and 32-bit edges, the equivalence of the two wide packings and the independence of neighbouring lanes are only shown by the bench, which sweeps operand patterns across all packings, operations and signedness settings and compares each result with lane-by-lane arithmetic.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    PACK_B8  = 2'b00,
    PACK_H16 = 2'b01,
    PACK_W32 = 2'b10,
    PACK_W32_ALT = 2'b11
  } pack_e;

  localparam int OP_SUB_BIT = 0;
  localparam int OP_SAT_BIT = 1;

  // log2 of the number of base segments per lane for a packing code
  function automatic logic [1:0] lane_log2(input logic [1:0] mode);
    case (pack_e'(mode))
      PACK_B8:  lane_log2 = 2'd0;
      PACK_H16: lane_log2 = 2'd1;
      default:  lane_log2 = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map #(
  parameter int NSEG = 8,
  localparam int IDXW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic [1:0]      mode,
  output logic [NSEG-1:0] seg_first,
  output logic [NSEG-1:0] seg_last,
  output logic [IDXW-1:0] seg_top [NSEG]
);
  import simd_pkg::*;

  logic [IDXW-1:0] span_m1;

  always_comb begin
    span_m1 = IDXW'((1 << lane_log2(mode)) - 1);
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam logic [IDXW-1:0] IDX = IDXW'(i);
    always_comb begin
      seg_first[i] = ((IDX & span_m1) == '0);
      seg_last[i]  = ((IDX & span_m1) == span_m1);
      seg_top[i]   = IDX | span_m1;
    end
  end

endmodule

// File: rtl/simd_seg_add.sv
module simd_seg_add #(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] a,
  input  logic [SEG_W-1:0] b,
  input  logic             cin,
  output logic [SEG_W-1:0] sum,
  output logic             cout,
  output logic             c_msb
);
  logic [SEG_W-1:0] low;
  logic [1:0]       high;

  always_comb begin
    low  = {1'b0, a[SEG_W-2:0]} + {1'b0, b[SEG_W-2:0]} + SEG_W'(cin);
    c_msb = low[SEG_W-1];
    high = {1'b0, a[SEG_W-1]} + {1'b0, b[SEG_W-1]} + {1'b0, c_msb};
    sum  = {high[0], low[SEG_W-2:0]};
    cout = high[1];
  end

endmodule

// File: rtl/simd_seg_clamp.sv
module simd_seg_clamp #(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] wrap_sum,
  input  logic             clamp,
  input  logic             signed_lane,
  input  logic             is_sub,
  input  logic             is_top,
  input  logic             neg_limit,
  output logic [SEG_W-1:0] res
);
  always_comb begin
    if (!clamp) begin
      res = wrap_sum;
    end else if (signed_lane) begin
      // positive limit 0111..1, negative limit 1000..0 across the lane
      if (is_top) res = {neg_limit, {(SEG_W-1){~neg_limit}}};
      else        res = {SEG_W{~neg_limit}};
    end else begin
      res = is_sub ? '0 : '1;
    end
  end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        in_mode,
  input  logic [1:0]        in_op,
  input  logic              in_signed,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_res
);
  import simd_pkg::*;

  localparam int NSEG = DATA_W / SEG_W;
  localparam int IDXW = (NSEG > 1) ? $clog2(NSEG) : 1;

  logic              op_sub;
  logic              op_sat;
  logic [NSEG-1:0]   seg_first;
  logic [NSEG-1:0]   seg_last;
  logic [IDXW-1:0]   seg_top [NSEG];
  logic [NSEG-1:0]   seg_cin;
  logic [NSEG-1:0]   seg_cout;
  logic [NSEG-1:0]   seg_cmsb;
  logic [NSEG-1:0]   seg_ovf;
  logic [NSEG-1:0]   a_msb;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] wrap_c;
  logic [DATA_W-1:0] res_c;

  assign op_sub = in_op[OP_SUB_BIT];
  assign op_sat = in_op[OP_SAT_BIT];
  assign b_eff  = op_sub ? ~in_b : in_b;

  simd_lane_map #(.NSEG(NSEG)) u_map (
    .mode      (in_mode),
    .seg_first (seg_first),
    .seg_last  (seg_last),
    .seg_top   (seg_top)
  );

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam int LO = i * SEG_W;

    // carry chain cut at lane starts; subtract injects +1 there
    if (i == 0) begin : g_c0
      assign seg_cin[i] = op_sub;
    end else begin : g_cn
      assign seg_cin[i] = seg_first[i] ? op_sub : seg_cout[i-1];
    end

    simd_seg_add #(.SEG_W(SEG_W)) u_add (
      .a     (in_a[LO +: SEG_W]),
      .b     (b_eff[LO +: SEG_W]),
      .cin   (seg_cin[i]),
      .sum   (wrap_c[LO +: SEG_W]),
      .cout  (seg_cout[i]),
      .c_msb (seg_cmsb[i])
    );

    assign a_msb[i] = in_a[LO + SEG_W - 1];

    // overflow flag, meaningful at the lane's top segment
    always_comb begin
      if (in_signed) seg_ovf[i] = seg_cmsb[i] ^ seg_cout[i];
      else           seg_ovf[i] = op_sub ? ~seg_cout[i] : seg_cout[i];
    end

    simd_seg_clamp #(.SEG_W(SEG_W)) u_clamp (
      .wrap_sum    (wrap_c[LO +: SEG_W]),
      .clamp       (op_sat & seg_ovf[seg_top[i]]),
      .signed_lane (in_signed),
      .is_sub      (op_sub),
      .is_top      (seg_last[i]),
      .neg_limit   (a_msb[seg_top[i]]),
      .res         (res_c[LO +: SEG_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_res <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_res <= res_c;
    end
  end

endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic [1:0]        in_mode,
  input logic [1:0]        in_op,
  input logic              in_signed,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_res
);
  logic [7:0] low_add;
  logic [7:0] low_sub;

  assign low_add = in_a[7:0] + in_b[7:0];
  assign low_sub = in_a[7:0] - in_b[7:0];

  p_vld_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  p_vld_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_res));

  p_low_wrap_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op == 2'b00) |=> out_res[7:0] == $past(low_add));

  p_low_wrap_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op == 2'b01) |=> out_res[7:0] == $past(low_sub));

  p_usat_add_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op == 2'b10 && !in_signed && in_mode == 2'b00)
      |=> out_res[7:0] >= $past(in_a[7:0]));

  p_usat_sub_ceil_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op == 2'b11 && !in_signed && in_mode == 2'b00)
      |=> out_res[7:0] <= $past(in_a[7:0]));

endmodule

bind simd_sat_adder simd_sat_adder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_vld    (in_vld),
  .in_a      (in_a),
  .in_b      (in_b),
  .in_mode   (in_mode),
  .in_op     (in_op),
  .in_signed (in_signed),
  .out_vld   (out_vld),
  .out_res   (out_res)
);

// File: tb/test_simd_sat_adder.sv
module test_simd_sat_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic [1:0]  in_mode = 2'b00;
  logic [1:0]  in_op = 2'b00;
  logic        in_signed = 1'b0;
  logic        out_vld;
  logic [63:0] out_res;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  simd_sat_adder i_simd_sat_adder (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
    .in_mode(in_mode), .in_op(in_op), .in_signed(in_signed),
    .out_vld(out_vld), .out_res(out_res)
  );

  // lane-by-lane arithmetic model
  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] mode, input logic [1:0] op,
                                        input logic sgn);
    int w = (mode == 2'b00) ? 8 : (mode == 2'b01) ? 16 : 32;
    longint span = longint'(1) << w;
    logic [63:0] r = '0;
    for (int k = 0; k < 64 / w; k++) begin
      longint ua = longint'((a >> (k * w)) & 64'(span - 1));
      longint ub = longint'((b >> (k * w)) & 64'(span - 1));
      longint va = ua, vb = ub, x, lo, hi;
      if (sgn) begin
        if (va >= span / 2) va -= span;
        if (vb >= span / 2) vb -= span;
        lo = -(span / 2); hi = span / 2 - 1;
      end else begin
        lo = 0; hi = span - 1;
      end
      x = op[0] ? va - vb : va + vb;
      if (op[1]) begin
        if (x > hi) x = hi;
        if (x < lo) x = lo;
      end
      r |= (64'(x) & 64'(span - 1)) << (k * w);
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] mode, input logic [1:0] op, input logic sgn);
    if (mode == 2'b11) return "R3";
    if (op == 2'b00) return "R4";
    if (op == 2'b01) return "R5";
    if (sgn) return "R8";
    if (op == 2'b10) return "R9";
    return "R10";
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, result is visible at the next falling edge
  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] mode,
                       input logic [1:0] op, input logic sgn, input logic [63:0] exp,
                       input string req);
    in_vld = 1'b1; in_a = a; in_b = b; in_mode = mode; in_op = op; in_signed = sgn;
    @(negedge clk);
    check(out_vld === 1'b1 && out_res === exp, req, out_res, exp);
  endtask

  task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [1:0] mode,
                     input logic [1:0] op, input logic sgn);
    apply(a, b, mode, op, sgn, model(a, b, mode, op, sgn), tag_of(mode, op, sgn));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    check(out_vld === 1'b0, "R1", {63'd0, out_vld}, 64'd0);  // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check(out_vld === 1'b0, "R1", {63'd0, out_vld}, 64'd0);

    // R6: all-ones plus one per lane wraps to zero with no spill, each mode
    apply('1, 64'h0101_0101_0101_0101, 2'b00, 2'b00, 1'b0, 64'd0, "R6");
    apply('1, 64'h0001_0001_0001_0001, 2'b01, 2'b00, 1'b0, 64'd0, "R6");
    apply('1, 64'h0000_0001_0000_0001, 2'b10, 2'b00, 1'b0, 64'd0, "R6");
    apply(64'd0, 64'h0000_0001_0000_0001, 2'b10, 2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
    // R8: 32-bit signed clamps, positive in lane 0, negative in lane 1
    apply(64'h8000_0000_7FFF_FFFF, 64'h8000_0000_0000_0001, 2'b10, 2'b10, 1'b1,
          64'h8000_0000_7FFF_FFFF, "R8");
    // R3: mode 11 matches mode 10
    apply(64'h8000_0000_7FFF_FFFF, 64'h8000_0000_0000_0001, 2'b11, 2'b10, 1'b1,
          64'h8000_0000_7FFF_FFFF, "R3");
    // R11: overflowing lane 0 next to exact lanes, 16-bit unsigned
    apply(64'h1234_0001_0010_FFFF, 64'h0001_0002_0020_0002, 2'b01, 2'b10, 1'b0,
          64'h1235_0003_0030_FFFF, "R11");
    // R7: wrap ignores signedness
    apply(64'h7F80_FF01_7FFF_8000, 64'h0180_0201_0001_8000, 2'b01, 2'b00, 1'b1,
          model(64'h7F80_FF01_7FFF_8000, 64'h0180_0201_0001_8000, 2'b01, 2'b00, 1'b0), "R7");

    // R2: idle cycle leaves result and strobe
    held = out_res;
    in_vld = 1'b0; in_a = 64'hDEAD_BEEF_0BAD_F00D; in_b = 64'h1357_9BDF_2468_ACE0;
    @(negedge clk);
    check(out_vld === 1'b0 && out_res === held, "R2", out_res, held);
    @(negedge clk);
    check(out_res === held, "R2", out_res, held);

    // near-exhaustive sweep over byte patterns, all packings, ops, signedness
    for (int ai = 0; ai < 256; ai += 5) begin
      for (int bi = 0; bi < 256; bi += 7) begin
        logic [7:0] x = 8'(ai);
        logic [7:0] y = 8'(bi);
        logic [63:0] a = {x, 8'h80 ^ y, ~x, y, x + 8'd1, 8'h7F, x, y};
        logic [63:0] b = {y, x, 8'h01, ~y, y, x ^ 8'h55, 8'hFF, y};
        for (int c = 0; c < 32; c++) begin
          run(a, b, 2'(c[4:3]), 2'(c[2:1]), c[0]);
        end
      end
    end

    // random words across every configuration
    for (int n = 0; n < 4000; n++) begin
      run({$urandom, $urandom}, {$urandom, $urandom}, 2'(n % 4), 2'((n / 4) % 4), n[4]);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule